// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block produces the clock-by-clock pin timing of a single memory or I/O transfer on a bus where one set of 16 lines carries the address first and the data afterwards. The 20-bit address is split across the shared lines and four upper lines. After the address state, those upper lines carry status. A requester presents an address, a direction, a memory/I/O select, a high-lane flag, a segment code and write data. The sequencer then walks the bus through T1, T2, T3, any number of wait states and T4.

The block pulses an address-latch enable in T1 so that an external latch can capture the address. It stretches the cycle while the addressed device holds `ready` low. It hands the bus to another master on `hold_req`, but only between cycles, and while the bus is handed over every bus output is released. Pins are modelled as separate value and output-enable ports, so that tristate buffers can be placed at the chip edge.

Top module: `mux_bus_seq`

## Requirements
- R1: Each cycle runs T1, T2, T3, zero or more Tw, then T4. A request (`req_valid`) is taken only in the idle state or in T4. `req_ack` is high in the cycle it is taken, and T1 follows on the next clock.
- R2: `ale` is high in T1 and low in every other state.
- R3: In T1, `ad_oe`=1 and `ad_out` = address bits 15..0. On a write (`req_write`=1), `ad_out` carries the write data with `ad_oe`=1 through T2, T3, Tw and T4. On a read, `ad_oe`=0 after T1.
- R4: In T1, `as_out` = address bits 19..16 for a memory cycle. For an I/O cycle (`req_io`=1) it is 4'b0000.
- R5: In T2, T3, Tw and T4, the status field `as_out` is laid out as follows. Bit 3 is 0. Bit 2 follows `ie_flag` in the same clock. Bits 1..0 hold the segment code: 00 extra, 01 stack, 10 code or none, 11 data.
- R6: `bhe_n` equals the inverse of `req_hi` (high data lane used) throughout T1..T4. It is 1 when idle.
- R7: `rd_n` is 0 exactly in T2, T3 and Tw of a read cycle, and 1 otherwise.
- R8: `ready` is sampled only at the end of T3 and of each Tw. While it is low there, a Tw follows. On a read, `ad_in` is captured at the edge where `ready` is high, and it is shown on `rd_data` with `rd_valid`=1 during T4. `ready` has no effect in T1 or T2.
- R9: `hold_req` is granted (`hold_ack`=1) only from idle or directly after T4, never in the middle of a cycle. While `hold_ack`=1, `ad_oe`, `as_oe`, `bhe_oe` and `rd_oe` are 0 and no request is taken. Hold has priority over a pending request.
- R10: A synchronous `rst` puts the block idle. In that state `ale`=0, `ad_oe`=0, `rd_n`=1, `bhe_n`=1, `hold_ack`=0 and `req_ack`=0 when no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Transfer request |
| req_addr | input | 20 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_hi | input | 1 | 1 = a byte moves on data lines 15..8 |
| req_seg | input | 2 | Segment code for status |
| req_wdata | input | 16 | Write data |
| ie_flag | input | 1 | Interrupt-enable flag shown in status |
| ready | input | 1 | Device completion, active high |
| hold_req | input | 1 | Bus request from another master |
| ad_in | input | 16 | Sampled shared lines (read data) |
| req_ack | output | 1 | Request taken this clock |
| ale | output | 1 | Address latch enable |
| ad_out | output | 16 | Shared line drive value |
| ad_oe | output | 1 | Shared line output enable |
| as_out | output | 4 | Upper address / status drive value |
| as_oe | output | 1 | Upper line output enable |
| bhe_n | output | 1 | High-lane enable, active low |
| bhe_oe | output | 1 | High-lane enable output enable |
| rd_n | output | 1 | Read strobe, active low |
| rd_oe | output | 1 | Read strobe output enable |
| hold_ack | output | 1 | Bus released to another master |
| rd_data | output | 16 | Captured read data |
| rd_valid | output | 1 | `rd_data` valid (T4 of a read) |

## Verification
The assertions assume that `ready`, `hold_req` and the request fields are synchronous to `clk`. They also assume that the request fields stay steady in the clock where `req_valid` is high. The bench meets these assumptions by changing every input only on the falling edge. It presents a request for a single clock and then withdraws it. The assertions also assume that `hold_req`, once raised, stays high until it is granted. The bench keeps it high across whole cycles for that reason.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_io,
  input  logic              req_hi,
  input  logic [1:0]        req_seg,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ie_flag,
  input  logic              ready,
  input  logic              hold_req,
  input  logic [DATA_W-1:0] ad_in,
  output logic              req_ack,
  output logic              ale,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] as_out,
  output logic              as_oe,
  output logic              bhe_n,
  output logic              bhe_oe,
  output logic              rd_n,
  output logic              rd_oe,
  output logic              hold_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int HI_W = ADDR_W - DATA_W;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_TW, S_T4, S_HOLD} bstate_t;

  bstate_t state, nstate;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              write_q, io_q, hi_q;
  logic [1:0]        seg_q;

  logic can_start, in_cycle, in_data, strobe_ph, done;

  assign can_start = (state == S_IDLE) || (state == S_T4);
  assign req_ack   = can_start && !hold_req && req_valid;
  assign in_cycle  = (state == S_T1) || in_data;
  assign in_data   = (state == S_T2) || (state == S_T3) || (state == S_TW) || (state == S_T4);
  assign strobe_ph = (state == S_T2) || (state == S_T3) || (state == S_TW);
  assign done      = ((state == S_T3) || (state == S_TW)) && ready;

  always_comb begin
    nstate = state;
    case (state)
      S_IDLE, S_T4: begin
        if (hold_req)       nstate = S_HOLD;
        else if (req_valid) nstate = S_T1;
        else                nstate = S_IDLE;
      end
      S_T1:    nstate = S_T2;
      S_T2:    nstate = S_T3;
      S_T3:    nstate = ready ? S_T4 : S_TW;
      S_TW:    nstate = ready ? S_T4 : S_TW;
      S_HOLD:  nstate = hold_req ? S_HOLD : S_IDLE;
      default: nstate = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      io_q    <= 1'b0;
      hi_q    <= 1'b0;
      seg_q   <= 2'b00;
      rd_data <= '0;
    end else begin
      state <= nstate;
      if (req_ack) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        write_q <= req_write;
        io_q    <= req_io;
        hi_q    <= req_hi;
        seg_q   <= req_seg;
      end
      if (done && !write_q) rd_data <= ad_in;
    end
  end

  assign hold_ack = (state == S_HOLD);
  assign ale      = (state == S_T1);

  assign ad_oe  = (state == S_T1) || (in_data && write_q);
  assign ad_out = (state == S_T1) ? addr_q[DATA_W-1:0] : wdata_q;

  logic [HI_W-1:0] status_v;
  assign status_v = {{(HI_W-3){1'b0}}, ie_flag, seg_q};

  always_comb begin
    if (state == S_T1)  as_out = io_q ? '0 : addr_q[ADDR_W-1:DATA_W];
    else if (in_data)   as_out = status_v;
    else                as_out = '0;
  end
  assign as_oe = !hold_ack;

  assign bhe_n  = in_cycle ? !hi_q : 1'b1;
  assign bhe_oe = !hold_ack;

  assign rd_n  = !(strobe_ph && !write_q);
  assign rd_oe = !hold_ack;

  assign rd_valid = (state == S_T4) && !write_q;

  p_seq_t1_r1: assert property (@(posedge clk) disable iff (rst)
    ale |=> (!ale && !hold_ack));
  p_ack_start_r1: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> ale);
  p_ale_single_r2: assert property (@(posedge clk) disable iff (rst)
    ale |-> !hold_ack && ad_oe && rd_n);
  p_no_contend_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe);
  p_wait_r8: assert property (@(posedge clk) disable iff (rst)
    (strobe_ph && (state != S_T2) && !ready) |=> (state == S_TW));
  p_float_r9: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> (!ad_oe && !as_oe && !bhe_oe && !rd_oe && !req_ack));
  p_hold_edge_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> ($past(state) == S_IDLE || $past(state) == S_T4));
  p_rdv_r8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
endmodule

// File: tb/mux_bus_seq_bench.sv
module mux_bus_seq_bench;
  logic clk = 0;
  logic rst = 1;
  logic req_valid = 0, req_write = 0, req_io = 0, req_hi = 0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_seg = '0;
  logic [15:0] req_wdata = '0, ad_in = '0;
  logic ie_flag = 0, ready = 1, hold_req = 0;
  logic req_ack, ale, ad_oe, as_oe, bhe_n, bhe_oe, rd_n, rd_oe, hold_ack, rd_valid;
  logic [15:0] ad_out, rd_data;
  logic [3:0]  as_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mux_bus_seq u_mux_bus_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_io(req_io), .req_hi(req_hi), .req_seg(req_seg),
    .req_wdata(req_wdata), .ie_flag(ie_flag), .ready(ready), .hold_req(hold_req),
    .ad_in(ad_in), .req_ack(req_ack), .ale(ale), .ad_out(ad_out), .ad_oe(ad_oe),
    .as_out(as_out), .as_oe(as_oe), .bhe_n(bhe_n), .bhe_oe(bhe_oe), .rd_n(rd_n),
    .rd_oe(rd_oe), .hold_ack(hold_ack), .rd_data(rd_data), .rd_valid(rd_valid));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_cycle(logic [19:0] a, logic wr, logic io, logic hi, logic [1:0] seg,
                           logic [15:0] wd, int nwait, logic [15:0] rdat);
    @(negedge clk);
    req_addr = a; req_write = wr; req_io = io; req_hi = hi; req_seg = seg;
    req_wdata = wd; req_valid = 1; ready = 0;
    #1 chk("R1", "req_ack", req_ack, 1);
    @(negedge clk);
    req_valid = 0; req_addr = ~a; req_wdata = ~wd;
    chk("R2", "ale T1", ale, 1);
    chk("R3", "ad T1", {ad_oe, ad_out}, {1'b1, a[15:0]});
    chk("R4", "upper T1", as_out, io ? 4'h0 : a[19:16]);
    chk("R6", "bhe T1", bhe_n, !hi);
    chk("R7", "rd_n T1", rd_n, 1);
    @(negedge clk);
    chk("R2", "ale T2", ale, 0);
    chk("R5", "status T2", as_out, {1'b0, ie_flag, seg});
    chk("R7", "rd_n T2", rd_n, wr);
    chk("R3", "ad T2", {ad_oe, ad_out}, wr ? {1'b1, wd} : {1'b0, ad_out});
    chk("R6", "bhe T2", bhe_n, !hi);
    @(negedge clk);
    ready = (nwait == 0); ad_in = rdat;
    ie_flag = ~ie_flag;
    #1 chk("R5", "status T3 ie live", as_out, {1'b0, ie_flag, seg});
    chk("R7", "rd_n T3", rd_n, wr);
    for (int i = 0; i < nwait; i++) begin
      @(negedge clk);
      chk("R8", "rd_n Tw", rd_n, wr);
      chk("R3", "ad_oe Tw", ad_oe, wr);
      ready = (i == nwait - 1);
    end
    @(negedge clk);
    ready = 0; ad_in = '0;
    chk("R7", "rd_n T4", rd_n, 1);
    chk("R8", "rd_valid T4", rd_valid, !wr);
    if (!wr) chk("R8", "rd_data T4", rd_data, rdat);
    chk("R5", "status T4", as_out, {1'b0, ie_flag, seg});
    chk("R6", "bhe T4", bhe_n, !hi);
    if (wr) chk("R3", "wdata T4", {ad_oe, ad_out}, {1'b1, wd});
    @(negedge clk);
    ready = 1;
    chk("R1", "idle after T4 ale", ale, 0);
    chk("R6", "bhe idle", bhe_n, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10", "ale", ale, 0);
    chk("R10", "ad_oe", ad_oe, 0);
    chk("R10", "rd_n", rd_n, 1);
    chk("R10", "bhe_n", bhe_n, 1);
    chk("R10", "hold_ack", hold_ack, 0);
    chk("R10", "req_ack", req_ack, 0);
  endtask

  task automatic t_hold_idle();
    @(negedge clk);
    hold_req = 1; req_valid = 1; req_addr = 20'h12345;
    #1 chk("R9", "no ack under hold", req_ack, 0);
    @(negedge clk);
    chk("R9", "hold_ack", hold_ack, 1);
    chk("R9", "all float", {ad_oe, as_oe, bhe_oe, rd_oe}, 4'b0000);
    chk("R9", "no start", ale, 0);
    req_valid = 0; hold_req = 0;
    @(negedge clk);
    chk("R9", "released", hold_ack, 0);
    chk("R9", "drivers back", {as_oe, bhe_oe, rd_oe}, 3'b111);
  endtask

  task automatic t_hold_mid();
    @(negedge clk);
    req_addr = 20'hA5A5A; req_write = 0; req_io = 0; req_hi = 0; req_seg = 2'b11;
    req_valid = 1; ready = 1;
    @(negedge clk);
    req_valid = 0; hold_req = 1;
    chk("R9", "T1 not granted", hold_ack, 0);
    @(negedge clk); chk("R9", "T2 not granted", hold_ack, 0);
    @(negedge clk); chk("R9", "T3 not granted", hold_ack, 0);
    @(negedge clk); chk("R9", "T4 not granted", {hold_ack, rd_valid}, 2'b01);
    @(negedge clk); chk("R9", "granted after T4", hold_ack, 1);
    hold_req = 0;
    @(negedge clk); chk("R9", "hold ends", hold_ack, 0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    req_addr = 20'h0F00F; req_write = 1; req_io = 0; req_hi = 1; req_seg = 2'b01;
    req_wdata = 16'h1111; req_valid = 1; ready = 1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    req_addr = 20'hF0123;
    @(negedge clk);
    chk("R1", "ack in T4", req_ack, 1);
    @(negedge clk);
    req_valid = 0;
    chk("R1", "T1 straight after T4", {ale, ad_out}, {1'b1, 16'h0123});
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    run_cycle(20'hABCDE, 0, 0, 1, 2'b10, 16'h0000, 0, 16'h5A3C);
    run_cycle(20'h3C001, 0, 0, 0, 2'b00, 16'h0000, 3, 16'hBEEF);
    run_cycle(20'hFEDCB, 1, 0, 1, 2'b01, 16'hC0DE, 1, 16'h0000);
    run_cycle(20'h7FFFF, 1, 1, 0, 2'b11, 16'h0042, 0, 16'h0000);
    run_cycle(20'h4F0F0, 0, 1, 1, 2'b10, 16'h0000, 2, 16'h9876);
    t_hold_idle();
    t_hold_mid();
    t_back_to_back();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=running expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule